// File: doc/BRIEF.md
# Serial FPGA Configuration Master

This block loads a bitstream into an FPGA whose configuration port is a plain serial slave. After a start pulse and a byte total, it first runs the clear handshake with the target: it pulls the program line low and waits for the target to pull its init line low. It then releases program and waits for init to rise again. After that it pulls configuration bytes from a valid/ready stream and shifts them out on a data pin, most significant bit first. The target samples each bit on the rising edge of a configuration clock that the block generates from the system clock.

Before each new byte the block checks the target's init and done lines. An init line that is low while done is still low means the target saw a corrupted frame, and the load stops at once. After the last byte the data pin stays high and the configuration clock keeps running until the target raises done. Every wait on the target has its own timeout. The outcome is reported on three one-hot flags that hold until the next start pulse.

Top module: `cfg_serial_master`

## Requirements
- R1: After reset prog_n, cclk and din are 1, and busy, s_ready, done_ok, err_timeout and err_crc are 0.
- R2: A start pulse while idle drives prog_n low and busy high in the next cycle. prog_n returns high only after init_n has been sampled low.
- R3: After prog_n is released, cclk does not fall and s_ready stays low until init_n has been sampled high again.
- R4: Each byte is shifted out most significant bit first. din changes only while cclk is driven low. Every low phase of cclk lasts exactly DIV_HALF system clocks, and every high phase lasts at least DIV_HALF.
- R5: s_ready is high only between bytes of a load. Exactly one byte is accepted for each 8 bits sent, and exactly byte_total bytes are accepted in a clean load.
- R6: Before each byte, if init_n is low while done_pin is low, the load ends with err_crc=1 and no further byte is taken.
- R7: After the last byte, din is 1 at every rising edge of cclk. cclk keeps toggling until done_pin is sampled high, and the load then ends with done_ok=1.
- R8: A wait for init_n low, for init_n high, or for done_pin that lasts TIMEOUT_CYC cycles ends the load with err_timeout=1. A load whose first wait times out keeps busy high for exactly TIMEOUT_CYC+1 cycles.
- R9: At most one of done_ok, err_timeout and err_crc is set, and none is set while busy. They hold their value while idle and clear on the next start.
- R10: A load with byte_total=0 goes straight from the init handshake to the postamble and accepts no byte.
- R11: A start pulse while busy has no effect on the running load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a load when idle |
| byte_total | input | CNT_W | Number of bytes in the load, sampled with start |
| s_valid | input | 1 | Stream byte available |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Block takes the stream byte this cycle |
| prog_n | output | 1 | Program line to the target, active low |
| cclk | output | 1 | Configuration clock; the target samples on its rising edge |
| din | output | 1 | Serial configuration data |
| init_n | input | 1 | Target init line, low while clearing or on error |
| done_pin | input | 1 | Target done line, high when configured |
| busy | output | 1 | A load is in progress |
| done_ok | output | 1 | Last load finished with done seen |
| err_timeout | output | 1 | Last load ended on a timeout |
| err_crc | output | 1 | Last load ended on a target error |

## Verification
The assertions assume that the target holds init_n low until well after prog_n goes low, and that init_n and done_pin change only at instants the design samples as stable levels. The bench target model meets both: it changes its lines only between clock edges, and it reacts to cclk and prog_n with delays of at least one cycle. The stream source may drop s_valid at random. It never offers a byte outside a load, and it never offers more bytes than byte_total. This keeps the acceptance count a pure function of the handshake.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SETTLE,
        ST_CHECK,
        ST_FETCH,
        ST_SHIFT,
        ST_POST
    } cfgm_state_e;
endpackage

// File: rtl/cfgm_div.sv
module cfgm_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] RELOAD = DW'(DIV - 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en || cnt_q == '0) cnt_d = RELOAD;
        else                    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && (cnt_q == '0);

    generate
        if (DIV > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R4
        end
    endgenerate
endmodule

// File: rtl/cfgm_timeout.sv
module cfgm_timeout #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic en,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] FULL = TW'(LIMIT);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload)                cnt_d = FULL;
        else if (en && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= FULL;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL); // R8
    AST_TMR_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !expired); // R8
endmodule

// File: rtl/cfg_serial_master.sv
module cfg_serial_master
    import cfgm_pkg::*;
#(
    parameter int DIV_HALF    = 4,
    parameter int TIMEOUT_CYC = 1_000_000,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_total,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    output logic             s_ready,
    output logic             prog_n,
    output logic             cclk,
    output logic             din,
    input  logic             init_n,
    input  logic             done_pin,
    output logic             busy,
    output logic             done_ok,
    output logic             err_timeout,
    output logic             err_crc
);
    typedef struct packed {
        cfgm_state_e          st;
        logic                 prog_n;
        logic                 cclk;
        logic                 din;
        logic [BYTE_W-1:0]    shreg;
        logic [BIT_CNT_W-1:0] bitcnt;
        logic [CNT_W-1:0]     left;
        logic                 ok;
        logic                 tmo;
        logic                 crc;
    } regs_t;

    localparam regs_t RST_VAL = '{ST_IDLE, 1'b1, 1'b1, 1'b1, '0, '0, '0,
                                  1'b0, 1'b0, 1'b0};
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    regs_t q, d;
    logic  tick, tick_en;
    logic  tmr_reload, tmr_en, expired;

    assign tick_en = (q.st == ST_SHIFT) || (q.st == ST_POST);
    assign tmr_en  = (q.st == ST_CLEAR) || (q.st == ST_SETTLE) || (q.st == ST_POST);

    cfgm_div #(.DIV(DIV_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .tick  (tick)
    );

    cfgm_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (tmr_reload),
        .en      (tmr_en),
        .expired (expired)
    );

    always_comb begin
        d = q;
        tmr_reload = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st     = ST_CLEAR;
                    d.prog_n = 1'b0;
                    d.cclk   = 1'b1;
                    d.din    = 1'b1;
                    d.left   = byte_total;
                    d.ok     = 1'b0;
                    d.tmo    = 1'b0;
                    d.crc    = 1'b0;
                    tmr_reload = 1'b1;
                end
            end
            ST_CLEAR: begin
                if (!init_n) begin
                    d.prog_n = 1'b1;
                    d.st     = ST_SETTLE;
                    tmr_reload = 1'b1;
                end else if (expired) begin
                    d.prog_n = 1'b1;
                    d.tmo    = 1'b1;
                    d.st     = ST_IDLE;
                end
            end
            ST_SETTLE: begin
                if (init_n) begin
                    if (q.left == '0) begin
                        d.st  = ST_POST;
                        d.din = 1'b1;
                        tmr_reload = 1'b1;
                    end else begin
                        d.st = ST_CHECK;
                    end
                end else if (expired) begin
                    d.tmo = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_CHECK: begin
                if (!init_n && !done_pin) begin
                    d.crc = 1'b1;
                    d.st  = ST_IDLE;
                end else begin
                    d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (s_valid) begin
                    d.shreg  = s_data;
                    d.bitcnt = '0;
                    d.st     = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (q.cclk) begin
                        d.cclk = 1'b0;
                        d.din  = q.shreg[BYTE_W-1];
                    end else begin
                        d.cclk   = 1'b1;
                        d.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                        d.bitcnt = q.bitcnt + 1'b1;
                        if (q.bitcnt == LAST_BIT) begin
                            d.left = q.left - 1'b1;
                            if (q.left == CNT_W'(1)) begin
                                d.st = ST_POST;
                                tmr_reload = 1'b1;
                            end else begin
                                d.st = ST_CHECK;
                            end
                        end
                    end
                end
            end
            ST_POST: begin
                if (done_pin) begin
                    d.ok   = 1'b1;
                    d.cclk = 1'b1;
                    d.st   = ST_IDLE;
                end else if (expired) begin
                    d.tmo  = 1'b1;
                    d.cclk = 1'b1;
                    d.st   = ST_IDLE;
                end else if (tick) begin
                    d.cclk = !q.cclk;
                    if (q.cclk) d.din = 1'b1;
                end
            end
            default: d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign s_ready     = (q.st == ST_FETCH);
    assign prog_n      = q.prog_n;
    assign cclk        = q.cclk;
    assign din         = q.din;
    assign busy        = (q.st != ST_IDLE);
    assign done_ok     = q.ok;
    assign err_timeout = q.tmo;
    assign err_crc     = q.crc;

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_ok, err_timeout, err_crc})); // R9
    AST_BUSY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(done_ok || err_timeout || err_crc)); // R9
    AST_PROG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_n) && busy) |-> !$past(init_n)); // R2
    AST_READY_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (busy && prog_n)); // R5
    AST_DIN_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk) |-> $stable(din)); // R4
    AST_CCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(cclk)); // R4
endmodule

// File: tb/cfg_serial_master_test.sv
module cfg_serial_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int TMO        = 300;
    localparam int CW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] byte_total = '0;
    logic          s_valid = 1'b0;
    logic [7:0]    s_data = 8'h00;
    logic          s_ready;
    logic          prog_n, cclk, din;
    logic          init_n = 1'b1;
    logic          done_pin = 1'b0;
    logic          busy, done_ok, err_timeout, err_crc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_serial_master #(.DIV_HALF(DIV), .TIMEOUT_CYC(TMO), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_total(byte_total),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .prog_n(prog_n), .cclk(cclk), .din(din), .init_n(init_n),
        .done_pin(done_pin), .busy(busy), .done_ok(done_ok),
        .err_timeout(err_timeout), .err_crc(err_crc)
    );

    // run configuration, written by the main sequence only
    logic [7:0] exp_mem [64];
    int run_id = 0, exp_n = 0, mode = 0, crc_after = 0, init_dly = 1, done_after = 1;
    int n_chk = 0, n_fail = 0;

    // target model state
    logic [7:0] rx_mem [64];
    logic [7:0] cur = 8'h00;
    int  bits = 0, nbytes = 0, post_edges = 0, low_cnt = 0, hold = 0;
    bit  cclk_prev = 1'b1, prog_prev = 1'b1, crc_fired = 1'b0;
    bit  viol_r2 = 1'b0, viol_r3 = 1'b0, viol_phase = 1'b0, viol_post = 1'b0;

    always @(negedge clk) begin
        if (!prog_prev && prog_n && busy && init_n) viol_r2 = 1'b1;
        if (!prog_n) begin
            done_pin = 1'b0; bits = 0; nbytes = 0; post_edges = 0; low_cnt = 0;
            crc_fired = 1'b0; viol_r3 = 1'b0; viol_phase = 1'b0; viol_post = 1'b0;
            if (mode != 1) begin
                if (hold < init_dly) hold++;
                else init_n = 1'b0;
            end
        end else begin
            if (prog_prev == 1'b0) hold = 0;
            if (!init_n && !crc_fired) begin
                if (!cclk || s_ready) viol_r3 = 1'b1;
                if (mode != 2) begin
                    if (hold < init_dly) hold++;
                    else init_n = 1'b1;
                end
            end
            if (busy && cclk && !cclk_prev) begin
                if (low_cnt != DIV) viol_phase = 1'b1;
                if (bits < 8 * exp_n) begin
                    cur = {cur[6:0], din};
                    bits++;
                    if (bits % 8 == 0) begin
                        rx_mem[nbytes] = cur;
                        nbytes++;
                        if (mode == 3 && nbytes == crc_after) begin
                            init_n = 1'b0;
                            crc_fired = 1'b1;
                        end
                    end
                end else begin
                    post_edges++;
                    if (!din) viol_post = 1'b1;
                    if (mode != 4 && post_edges >= done_after) done_pin = 1'b1;
                end
            end
            if (!cclk) low_cnt++;
            else low_cnt = 0;
        end
        cclk_prev = cclk;
        prog_prev = prog_n;
    end

    // stream source
    int idx = 0, seen_id = 0;
    bit acc = 1'b0;
    always @(negedge clk) begin
        if (run_id != seen_id) begin
            idx = 0; acc = 1'b0; seen_id = run_id;
        end
        if (acc) idx++;
        s_valid = (idx < exp_n) && busy && ($urandom % 4 != 0);
        s_data  = (idx < 64) ? exp_mem[idx] : 8'h00;
        acc     = s_valid && s_ready;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [2:0] exp_status(input int m);
        case (m)
            0: return 3'b100;
            3: return 3'b001;
            default: return 3'b010;
        endcase
    endfunction

    function automatic int exp_bytes(input int m, input int n, input int ce);
        case (m)
            0, 4: return n;
            3: return ce;
            default: return 0;
        endcase
    endfunction

    task automatic run(input int n, input int m, input int ce, input int dly,
                       input int da, input bit poke, input bit directed);
        int cyc;
        int eb;
        logic [2:0] st;
        @(negedge clk); #1;
        for (int k = 0; k < 64; k++) exp_mem[k] = 8'($urandom);
        if (directed) begin
            exp_mem[0] = 8'h80; exp_mem[1] = 8'h01; exp_mem[2] = 8'hFF; exp_mem[3] = 8'h00;
        end
        exp_n = n; mode = m; crc_after = ce; init_dly = dly; done_after = da;
        run_id++;
        byte_total = CW'(n);
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        chk(prog_n == 1'b0 && busy == 1'b1, "R2 prog low and busy after start", {prog_n, busy}, 2'b01);
        chk({done_ok, err_timeout, err_crc} == 3'b000, "R9 status cleared by start",
            {done_ok, err_timeout, err_crc}, 0);
        cyc = 1;
        while (cyc < 5000) begin
            @(negedge clk);
            if (!busy) break;
            cyc++;
            if (poke && cyc == 40) begin
                #1 start = 1'b1;
                @(negedge clk); #1 start = 1'b0;
                cyc++;
                chk(prog_n == 1'b1 && busy == 1'b1, "R11 start while busy ignored", {prog_n, busy}, 2'b11);
            end
        end
        st = exp_status(m);
        chk({done_ok, err_timeout, err_crc} == st, "R6/R7/R8 final status",
            {done_ok, err_timeout, err_crc}, st);
        if (m == 1) chk(cyc == TMO + 1, "R8 busy length on timeout", cyc, TMO + 1);
        eb = exp_bytes(m, n, ce);
        chk(nbytes == eb, "R5 bytes delivered", nbytes, eb);
        for (int k = 0; k < eb && k < 64; k++)
            chk(rx_mem[k] == exp_mem[k], "R4 byte value msb first", rx_mem[k], exp_mem[k]);
        if (m == 0) chk(idx == n, "R5 bytes accepted from stream", idx, n);
        if (m == 3) chk(idx == ce, "R6 no byte taken after error", idx, ce);
        if (n == 0 && m == 0) chk(idx == 0 && nbytes == 0, "R10 empty load skips data", nbytes, 0);
        chk(!viol_r2, "R2 prog released only after init low", viol_r2, 0);
        chk(!viol_r3, "R3 no clock or ready while init low", viol_r3, 0);
        chk(!viol_phase, "R4 low phase length", viol_phase, 0);
        chk(!viol_post, "R7 din high in postamble", viol_post, 0);
        if (m == 0) chk(post_edges == da, "R7 clocks until done", post_edges, da);
        repeat (20) @(negedge clk);
        chk({done_ok, err_timeout, err_crc} == st && !busy, "R9 status held while idle",
            {done_ok, err_timeout, err_crc}, st);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prog_n && cclk && din, "R1 reset pins", {prog_n, cclk, din}, 3'b111);
        chk(!busy && !s_ready && !done_ok && !err_timeout && !err_crc, "R1 reset status",
            {busy, s_ready, done_ok, err_timeout, err_crc}, 0);
        run(4, 0, 0, 2, 3, 1'b0, 1'b1);
        run(0, 0, 0, 1, 2, 1'b0, 1'b0);   // R10
        run(1, 0, 0, 1, 1, 1'b0, 1'b0);
        run(4, 0, 0, 3, 2, 1'b1, 1'b0);   // R11
        run(3, 1, 0, 1, 1, 1'b0, 1'b0);   // R8 init never low
        run(3, 2, 0, 1, 1, 1'b0, 1'b0);   // R8 init never high
        run(2, 4, 0, 1, 1, 1'b0, 1'b0);   // R8 done never high
        for (int r = 0; r < 10; r++)
            run($urandom_range(1, 8), 0, 0, $urandom_range(1, 5), $urandom_range(1, 6), 1'b0, 1'b0);
        for (int r = 0; r < 4; r++) begin
            int n = $urandom_range(3, 6);
            run(n, 3, $urandom_range(1, n - 1), $urandom_range(1, 4), 1, 1'b0, 1'b0); // R6
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end
endmodule